// File: doc/BRIEF.md
# Serial Port Byte Mover with Receive and Transmit Channels

This block carries bytes between a UART-style serial core and system memory with no CPU copying. It has two independent channels. The receive channel writes each received byte to memory. The transmit channel reads bytes from memory and hands them to the transmitter. Each channel keeps its own address pointer, remaining-byte counter and enable bit. Software loads the pointer and counter before it enables a channel. On every transfer the pointer advances by one and the counter drops by one. When the counter reaches zero, the channel raises an end-of-block flag and turns itself off in the same cycle.

The serial core is seen only through single-cycle strobes: byte received, receive errors (overrun, framing, parity), transmit shift register empty, CPU write to the transmit buffer and CPU read of the receive buffer. Memory is reached through a single-byte request/acknowledge port. The receive channel wins when both channels ask at once.

In search mode, a received byte equal to the programmed search character is dropped and its match is flagged. Any receive error freezes the receive channel until software clears the error. An overrun also needs a receive-buffer read before transfers resume. While a channel is enabled, its ordinary per-byte interrupt flag is held off, so only end-of-block and error conditions interrupt.

Top module: `sdma_ctrl`

## Requirements
- R1: After reset, every register reads zero (rx pointer addr 0, rx count addr 1, tx pointer addr 2, tx count addr 3, control addr 4, flags addr 5, search char addr 6), mem_req is low and both interrupts are low.
- R2: With receive enabled (control bit 0), each rx_evt strobe writes rx_byte to memory at the rx pointer through one mem_req/mem_ack handshake. The pointer then increments and the count decrements. The address is held stable while the request waits.
- R3: The transfer that takes a channel's count to zero sets its end-of-block flag (flags bit 0 receive, bit 1 transmit) and clears its enable (control bit 0 or 1) in the same cycle.
- R4: With search mode on (control bit 2), a received byte equal to the search character (addr 6, low 8 bits) makes no memory write, leaves the count unchanged and sets flags bit 5.
- R5: A framing (flags bit 3) or parity (flags bit 4) error freezes the receive channel. Bytes received while frozen are not written. Transfers resume once the flag is cleared.
- R6: An overrun error sets flags bit 2. Receive transfers resume only after that flag is cleared and rxbuf_rd has been pulsed.
- R7: An rx_evt that arrives while the previous receive write still awaits mem_ack is treated as an overrun (flags bit 2 set, channel frozen). The pending write still completes.
- R8: With transmit enabled (control bit 1), a txbuf_wr strobe starts a memory read at the tx pointer. The returned byte appears on tx_data with a one-cycle tx_load pulse.
- R9: A tx_empty strobe starts the next transmit fetch only when the block-select bit (control bit 3) is 0. With the bit at 1 it starts nothing.
- R10: Flags bit 6 (receive pending) is set by rx_evt only while receive is disabled. Flags bit 7 (transmitter idle) is set by tx_empty only while transmit is disabled. irq_rx is the registered OR of flags bits 0 and 2 to 6. irq_tx is the registered OR of flags bits 1 and 7.
- R11: When receive and transmit requests are pending together and the memory port is idle, the receive write is issued first.
- R12: Writing 1 to a flags bit clears it. Writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data valid next cycle |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Registered read data |
| rx_evt | input | 1 | Serial core received a byte |
| rx_byte | input | 8 | Received byte |
| rx_err_ovr | input | 1 | Overrun error strobe |
| rx_err_frm | input | 1 | Framing error strobe |
| rx_err_par | input | 1 | Parity error strobe |
| rxbuf_rd | input | 1 | CPU read of the receive buffer |
| txbuf_wr | input | 1 | CPU write to the transmit buffer |
| tx_empty | input | 1 | Transmit shift register empty strobe |
| tx_load | output | 1 | Byte for the transmitter is valid |
| tx_data | output | 8 | Byte for the transmitter |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | 1 = write (receive), 0 = read (transmit) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, ends the request |
| mem_rdata | input | 8 | Memory read data, valid with mem_ack |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
A vector table sends a stream of received bytes in search mode. Ordinary bytes and search-character bytes are mixed, and the stream ends exactly at the count limit. This separates a skip (no write, count kept) from a normal transfer and shows that end-of-block fires on the last counted byte, not the last byte seen. Directed sequences then check the following:
- framing and overrun freezes, including the buffer-read condition an overrun adds;
- an overrun forced by stalling the acknowledge;
- transmit started by a buffer write and continued by shift-empty events, with block-select both clear and set;
- a simultaneous receive and transmit request, where the order of memory accesses shows the priority.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic [2:0] {
    RG_RXPTR = 3'd0,
    RG_RXCNT = 3'd1,
    RG_TXPTR = 3'd2,
    RG_TXCNT = 3'd3,
    RG_CTRL  = 3'd4,
    RG_FLAGS = 3'd5,
    RG_SCHR  = 3'd6
  } reg_sel_e;

  localparam int CT_RXEN = 0;
  localparam int CT_TXEN = 1;
  localparam int CT_SRCH = 2;
  localparam int CT_BSEL = 3;

  localparam int FL_RXEOB  = 0;
  localparam int FL_TXEOB  = 1;
  localparam int FL_OVR    = 2;
  localparam int FL_FRM    = 3;
  localparam int FL_PAR    = 4;
  localparam int FL_MCH    = 5;
  localparam int FL_RXPEND = 6;
  localparam int FL_TXIDLE = 7;
  localparam int FL_W      = 8;
endpackage

// File: rtl/sdma_rx_chan.sv
module sdma_rx_chan #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_ptr,
  input  logic          ld_cnt,
  input  logic [AW-1:0] ptr_val,
  input  logic [CW-1:0] cnt_val,
  input  logic          ctl_wr,
  input  logic          ctl_en,
  input  logic          clr_eob,
  input  logic          clr_ovr,
  input  logic          clr_frm,
  input  logic          clr_par,
  input  logic          clr_mch,
  input  logic          clr_pend,
  input  logic          search_en,
  input  logic [7:0]    search_chr,
  input  logic          evt,
  input  logic [7:0]    byte_in,
  input  logic          err_ovr,
  input  logic          err_frm,
  input  logic          err_par,
  input  logic          buf_rd,
  input  logic          done,
  output logic          req,
  output logic [7:0]    wdata,
  output logic [AW-1:0] ptr,
  output logic [CW-1:0] cnt,
  output logic          en,
  output logic          eob,
  output logic          ovr,
  output logic          frm,
  output logic          par,
  output logic          mch,
  output logic          pend
);
  logic rd_owed;
  logic frozen;
  logic hit;
  logic last;
  logic take;

  assign frozen = ovr | frm | par | rd_owed;
  assign hit    = search_en && (byte_in == search_chr);
  assign last   = done && (cnt == CW'(1));
  assign take   = evt && en && !frozen && (cnt != '0) && !last;

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0; wdata <= '0; ptr <= '0; cnt <= '0; en <= 1'b0;
      eob <= 1'b0; ovr <= 1'b0; frm <= 1'b0; par <= 1'b0;
      mch <= 1'b0; pend <= 1'b0; rd_owed <= 1'b0;
    end else begin
      if (ctl_wr) en <= ctl_en;
      if (clr_eob)  eob  <= 1'b0;
      if (clr_ovr)  ovr  <= 1'b0;
      if (clr_frm)  frm  <= 1'b0;
      if (clr_par)  par  <= 1'b0;
      if (clr_mch)  mch  <= 1'b0;
      if (clr_pend) pend <= 1'b0;
      if (buf_rd)   rd_owed <= 1'b0;
      if (done) begin
        req <= 1'b0;
        ptr <= ptr + AW'(1);
        cnt <= cnt - CW'(1);
        if (last) begin
          eob <= 1'b1;
          en  <= 1'b0;
        end
      end
      if (take) begin
        if (hit) begin
          mch <= 1'b1;
        end else if (req && !done) begin
          ovr     <= 1'b1;
          rd_owed <= 1'b1;
        end else begin
          req   <= 1'b1;
          wdata <= byte_in;
        end
      end
      if (evt && !en) pend <= 1'b1;
      if (err_ovr) begin
        ovr     <= 1'b1;
        rd_owed <= 1'b1;
      end
      if (err_frm) frm <= 1'b1;
      if (err_par) par <= 1'b1;
      if (ld_ptr) ptr <= ptr_val;
      if (ld_cnt) cnt <= cnt_val;
    end
  end

  assert_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    frozen |=> !$rose(req))
    else $error("frozen receive channel issued a request");

  assert_skip_match_R4: assert property (@(posedge clk) disable iff (rst)
    (evt && en && !frozen && hit) |=> !$rose(req))
    else $error("matched character was forwarded");

  assert_eob_disables_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(eob) |-> !en)
    else $error("receive end-of-block left channel enabled");

  assert_pend_held_R10: assert property (@(posedge clk) disable iff (rst)
    (en && !clr_pend) |=> !$rose(pend))
    else $error("receive pending set while channel enabled");
endmodule

// File: rtl/sdma_tx_chan.sv
module sdma_tx_chan #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_ptr,
  input  logic          ld_cnt,
  input  logic [AW-1:0] ptr_val,
  input  logic [CW-1:0] cnt_val,
  input  logic          ctl_wr,
  input  logic          ctl_en,
  input  logic          clr_eob,
  input  logic          clr_idle,
  input  logic          block_sel,
  input  logic          cpu_wr,
  input  logic          sr_empty,
  input  logic          done,
  input  logic [7:0]    rdata,
  output logic          req,
  output logic [AW-1:0] ptr,
  output logic [CW-1:0] cnt,
  output logic          en,
  output logic          eob,
  output logic          idle,
  output logic          load,
  output logic [7:0]    ldata
);
  logic trig;
  logic last;

  assign last = done && (cnt == CW'(1));
  assign trig = en && !req && (cnt != '0) &&
                (cpu_wr || (sr_empty && !block_sel));

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0; ptr <= '0; cnt <= '0; en <= 1'b0;
      eob <= 1'b0; idle <= 1'b0; load <= 1'b0; ldata <= '0;
    end else begin
      load <= 1'b0;
      if (ctl_wr)   en   <= ctl_en;
      if (clr_eob)  eob  <= 1'b0;
      if (clr_idle) idle <= 1'b0;
      if (trig) req <= 1'b1;
      if (done) begin
        req   <= 1'b0;
        load  <= 1'b1;
        ldata <= rdata;
        ptr   <= ptr + AW'(1);
        cnt   <= cnt - CW'(1);
        if (last) begin
          eob <= 1'b1;
          en  <= 1'b0;
        end
      end
      if (sr_empty && !en) idle <= 1'b1;
      if (ld_ptr) ptr <= ptr_val;
      if (ld_cnt) cnt <= cnt_val;
    end
  end

  assert_load_follows_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> load)
    else $error("fetched byte not presented to transmitter");

  assert_bsel_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    (sr_empty && block_sel && !cpu_wr) |=> !$rose(req))
    else $error("shift-empty started a fetch with block-select set");

  assert_tx_eob_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(eob) |-> !en)
    else $error("transmit end-of-block left channel enabled");
endmodule

// File: rtl/sdma_arb.sv
module sdma_arb #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_req,
  input  logic [AW-1:0] rx_addr,
  input  logic [7:0]    rx_data,
  input  logic          tx_req,
  input  logic [AW-1:0] tx_addr,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          rx_done,
  output logic          tx_done
);
  logic own_rx;

  assign rx_done = mem_req && mem_ack && own_rx;
  assign tx_done = mem_req && mem_ack && !own_rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0;
      mem_wdata <= '0; own_rx <= 1'b0;
    end else if (mem_req) begin
      if (mem_ack) mem_req <= 1'b0;
    end else if (rx_req) begin
      mem_req   <= 1'b1;
      mem_we    <= 1'b1;
      mem_addr  <= rx_addr;
      mem_wdata <= rx_data;
      own_rx    <= 1'b1;
    end else if (tx_req) begin
      mem_req   <= 1'b1;
      mem_we    <= 1'b0;
      mem_addr  <= tx_addr;
      own_rx    <= 1'b0;
    end
  end

  assert_rx_first_R11: assert property (@(posedge clk) disable iff (rst)
    (!mem_req && rx_req) |=> (mem_req && mem_we))
    else $error("receive request not served first");

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)))
    else $error("memory request changed before acknowledge");
endmodule

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
  import sdma_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             rx_evt,
  input  logic [7:0]       rx_byte,
  input  logic             rx_err_ovr,
  input  logic             rx_err_frm,
  input  logic             rx_err_par,
  input  logic             rxbuf_rd,
  input  logic             txbuf_wr,
  input  logic             tx_empty,
  output logic             tx_load,
  output logic [7:0]       tx_data,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic             mem_ack,
  input  logic [7:0]       mem_rdata,
  output logic             irq_rx,
  output logic             irq_tx
);
  logic [REG_W-1:0] unused_wdata;
  assign unused_wdata = reg_wdata;

  logic          wr_ctl, wr_flg;
  logic [FL_W-1:0] clr;
  logic          search_en, block_sel;
  logic [7:0]    search_chr;

  logic          rx_req, rx_done, rx_en;
  logic [7:0]    rx_wd;
  logic [AW-1:0] rx_ptr;
  logic [CW-1:0] rx_cnt;
  logic          tx_req, tx_done, tx_en;
  logic [AW-1:0] tx_ptr;
  logic [CW-1:0] tx_cnt;
  logic [FL_W-1:0] flags;

  assign wr_ctl = reg_wr && (reg_addr == RG_CTRL);
  assign wr_flg = reg_wr && (reg_addr == RG_FLAGS);
  assign clr    = wr_flg ? reg_wdata[FL_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      search_en <= 1'b0; block_sel <= 1'b0; search_chr <= '0;
    end else begin
      if (wr_ctl) begin
        search_en <= reg_wdata[CT_SRCH];
        block_sel <= reg_wdata[CT_BSEL];
      end
      if (reg_wr && (reg_addr == RG_SCHR)) search_chr <= reg_wdata[7:0];
    end
  end

  sdma_rx_chan #(.AW(AW), .CW(CW)) u_rx (
    .clk(clk), .rst(rst),
    .ld_ptr(reg_wr && (reg_addr == RG_RXPTR)),
    .ld_cnt(reg_wr && (reg_addr == RG_RXCNT)),
    .ptr_val(reg_wdata[AW-1:0]), .cnt_val(reg_wdata[CW-1:0]),
    .ctl_wr(wr_ctl), .ctl_en(reg_wdata[CT_RXEN]),
    .clr_eob(clr[FL_RXEOB]), .clr_ovr(clr[FL_OVR]), .clr_frm(clr[FL_FRM]),
    .clr_par(clr[FL_PAR]), .clr_mch(clr[FL_MCH]), .clr_pend(clr[FL_RXPEND]),
    .search_en(search_en), .search_chr(search_chr),
    .evt(rx_evt), .byte_in(rx_byte),
    .err_ovr(rx_err_ovr), .err_frm(rx_err_frm), .err_par(rx_err_par),
    .buf_rd(rxbuf_rd), .done(rx_done),
    .req(rx_req), .wdata(rx_wd), .ptr(rx_ptr), .cnt(rx_cnt), .en(rx_en),
    .eob(flags[FL_RXEOB]), .ovr(flags[FL_OVR]), .frm(flags[FL_FRM]),
    .par(flags[FL_PAR]), .mch(flags[FL_MCH]), .pend(flags[FL_RXPEND])
  );

  sdma_tx_chan #(.AW(AW), .CW(CW)) u_tx (
    .clk(clk), .rst(rst),
    .ld_ptr(reg_wr && (reg_addr == RG_TXPTR)),
    .ld_cnt(reg_wr && (reg_addr == RG_TXCNT)),
    .ptr_val(reg_wdata[AW-1:0]), .cnt_val(reg_wdata[CW-1:0]),
    .ctl_wr(wr_ctl), .ctl_en(reg_wdata[CT_TXEN]),
    .clr_eob(clr[FL_TXEOB]), .clr_idle(clr[FL_TXIDLE]),
    .block_sel(block_sel), .cpu_wr(txbuf_wr), .sr_empty(tx_empty),
    .done(tx_done), .rdata(mem_rdata),
    .req(tx_req), .ptr(tx_ptr), .cnt(tx_cnt), .en(tx_en),
    .eob(flags[FL_TXEOB]), .idle(flags[FL_TXIDLE]),
    .load(tx_load), .ldata(tx_data)
  );

  sdma_arb #(.AW(AW)) u_arb (
    .clk(clk), .rst(rst),
    .rx_req(rx_req), .rx_addr(rx_ptr), .rx_data(rx_wd),
    .tx_req(tx_req), .tx_addr(tx_ptr),
    .mem_ack(mem_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rx_done(rx_done), .tx_done(tx_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_rx    <= 1'b0;
      irq_tx    <= 1'b0;
    end else begin
      irq_rx <= flags[FL_RXEOB] | flags[FL_OVR] | flags[FL_FRM] |
                flags[FL_PAR] | flags[FL_MCH] | flags[FL_RXPEND];
      irq_tx <= flags[FL_TXEOB] | flags[FL_TXIDLE];
      if (reg_rd) begin
        case (reg_addr)
          RG_RXPTR: reg_rdata <= REG_W'(rx_ptr);
          RG_RXCNT: reg_rdata <= REG_W'(rx_cnt);
          RG_TXPTR: reg_rdata <= REG_W'(tx_ptr);
          RG_TXCNT: reg_rdata <= REG_W'(tx_cnt);
          RG_CTRL:  reg_rdata <= REG_W'({block_sel, search_en, tx_en, rx_en});
          RG_FLAGS: reg_rdata <= REG_W'(flags);
          RG_SCHR:  reg_rdata <= REG_W'(search_chr);
          default:  reg_rdata <= '0;
        endcase
      end
    end
  end

  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (flags == '0) |=> (!irq_rx && !irq_tx))
    else $error("interrupt raised with no flag set");
endmodule

// File: tb/tb_sdma_ctrl.sv
`timescale 1ns/1ps
module tb_sdma_ctrl;
  localparam int AW = 16, CW = 16, REG_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [REG_W-1:0] reg_wdata = 0, reg_rdata;
  logic rx_evt = 0, rx_err_ovr = 0, rx_err_frm = 0, rx_err_par = 0;
  logic [7:0] rx_byte = 0;
  logic rxbuf_rd = 0, txbuf_wr = 0, tx_empty = 0;
  logic tx_load; logic [7:0] tx_data;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic irq_rx, irq_tx;
  logic ack_en = 1'b1;

  sdma_ctrl #(.AW(AW), .CW(CW), .REG_W(REG_W)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_evt(rx_evt), .rx_byte(rx_byte), .rx_err_ovr(rx_err_ovr),
    .rx_err_frm(rx_err_frm), .rx_err_par(rx_err_par), .rxbuf_rd(rxbuf_rd),
    .txbuf_wr(txbuf_wr), .tx_empty(tx_empty), .tx_load(tx_load),
    .tx_data(tx_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  // memory model: read data is a fixed function of the address
  logic [7:0] bmem [256];
  logic       acc_we [64];
  logic [7:0] txlog [64];
  int nwr = 0, nacc = 0, ntx = 0;
  assign mem_rdata = mem_addr[7:0] ^ 8'hA5;

  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else     mem_ack <= mem_req && !mem_ack && ack_en;
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        bmem[mem_addr[7:0]] <= mem_wdata;
        nwr <= nwr + 1;
      end
      acc_we[nacc[5:0]] <= mem_we;
      nacc <= nacc + 1;
    end
    if (tx_load) begin
      txlog[ntx[5:0]] <= tx_data;
      ntx <= ntx + 1;
    end
  end

  int nchk = 0, nfail = 0;

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [REG_W-1:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rreg(input logic [2:0] a, output int d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = int'(reg_rdata);
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_evt = 1;
    @(negedge clk); rx_evt = 0;
  endtask

  task automatic pulse_txwr();
    @(negedge clk); txbuf_wr = 1; @(negedge clk); txbuf_wr = 0;
  endtask

  task automatic pulse_empty();
    @(negedge clk); tx_empty = 1; @(negedge clk); tx_empty = 0;
  endtask

  task automatic pulse_bufrd();
    @(negedge clk); rxbuf_rd = 1; @(negedge clk); rxbuf_rd = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  // bit 8 set: byte equals the search character and must be skipped
  localparam logic [8:0] RXV [8] = '{9'h011, 9'h0C3, 9'h12A, 9'h07E,
                                     9'h0FF, 9'h12A, 9'h000, 9'h055};

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int v, eptr, ecnt, w0, base;
    idle(3);
    @(negedge clk); rst = 0;
    idle(1);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rreg(3'(a), v);
      check($sformatf("R1 reg%0d", a), v, 0);
    end
    check("R1 mem_req", int'(mem_req), 0);
    check("R1 irqs", int'({irq_rx, irq_tx}), 0);

    // vector table: search mode receive stream
    wreg(3'd0, 16'h0040);
    wreg(3'd1, 16'd6);
    wreg(3'd6, 16'h002A);
    wreg(3'd4, 16'h0005);
    eptr = 'h40; ecnt = 6;
    for (int i = 0; i < 8; i++) begin
      w0 = nwr;
      rx_send(RXV[i][7:0]);
      idle(6);
      if (RXV[i][8]) begin
        check("R4 no write on match", nwr, w0);
        rreg(3'd1, v); check("R4 count kept", v, ecnt);
        rreg(3'd5, v); check("R4 match flag", (v >> 5) & 1, 1);
        wreg(3'd5, 16'h0020);
      end else begin
        check("R2 one write", nwr, w0 + 1);
        check("R2 data at pointer", int'(bmem[eptr[7:0]]), int'(RXV[i][7:0]));
        eptr++; ecnt--;
      end
    end
    rreg(3'd0, v); check("R2 pointer advanced", v, 'h46);
    rreg(3'd1, v); check("R3 rx count zero", v, 0);
    rreg(3'd5, v); check("R3 rx eob flag", v, 1);
    rreg(3'd4, v); check("R3 rx enable cleared", v & 1, 0);
    check("R10 irq_rx on eob", int'(irq_rx), 1);
    wreg(3'd5, 16'h0000);
    rreg(3'd5, v); check("R12 zero write keeps flag", v, 1);
    wreg(3'd5, 16'h0001);
    idle(2);
    rreg(3'd5, v); check("R12 flag cleared", v, 0);
    check("R10 irq_rx drops", int'(irq_rx), 0);

    // R10 receive pending only when disabled
    w0 = nwr;
    rx_send(8'h33); idle(4);
    rreg(3'd5, v); check("R10 rx pending when disabled", v, 'h40);
    check("R10 no write when disabled", nwr, w0);
    wreg(3'd5, 16'h0040);

    // R5 framing freeze
    wreg(3'd0, 16'h0080); wreg(3'd1, 16'd4); wreg(3'd4, 16'h0001);
    @(negedge clk); rx_err_frm = 1; @(negedge clk); rx_err_frm = 0;
    w0 = nwr;
    rx_send(8'h91); idle(6);
    check("R5 frozen after framing", nwr, w0);
    rreg(3'd5, v); check("R5 framing flag", v, 'h08);
    @(negedge clk); rx_err_par = 1; @(negedge clk); rx_err_par = 0;
    rreg(3'd5, v); check("R5 parity flag", v, 'h18);
    wreg(3'd5, 16'h0018);
    rx_send(8'h92); idle(6);
    check("R5 resumes after clear", int'(bmem[8'h80]), 'h92);

    // R6 overrun needs flag clear and buffer read
    @(negedge clk); rx_err_ovr = 1; @(negedge clk); rx_err_ovr = 0;
    wreg(3'd5, 16'h0004);
    w0 = nwr;
    rx_send(8'h93); idle(6);
    check("R6 still frozen before buffer read", nwr, w0);
    pulse_bufrd();
    rx_send(8'h94); idle(6);
    check("R6 resumes after buffer read", int'(bmem[8'h81]), 'h94);

    // R7 event while write awaits acknowledge
    ack_en = 0;
    rx_send(8'h95); idle(3);
    rx_send(8'h96); idle(2);
    rreg(3'd5, v); check("R7 overrun from stalled write", v & 'h04, 'h04);
    ack_en = 1; idle(4);
    check("R7 pending write completes", int'(bmem[8'h82]), 'h95);
    wreg(3'd5, 16'h0004); pulse_bufrd();
    rx_send(8'h97); idle(6);
    check("R7 recovered write", int'(bmem[8'h83]), 'h97);
    rreg(3'd4, v); check("R3 rx disabled after block", v & 1, 0);
    wreg(3'd5, 16'h00FF);

    // R8 / R9 transmit
    wreg(3'd2, 16'h0010); wreg(3'd3, 16'd3); wreg(3'd4, 16'h0002);
    pulse_txwr(); idle(6);
    check("R8 one byte after buffer write", ntx, 1);
    check("R8 byte from pointer", int'(txlog[0]), 'h10 ^ 'hA5);
    pulse_empty(); idle(6);
    check("R9 fetch on shift empty", ntx, 2);
    check("R9 second byte", int'(txlog[1]), 'h11 ^ 'hA5);
    rreg(3'd5, v); check("R10 idle flag held while enabled", v, 0);
    check("R10 irq_tx quiet while enabled", int'(irq_tx), 0);
    pulse_empty(); idle(6);
    check("R9 third byte", int'(txlog[2]), 'h12 ^ 'hA5);
    rreg(3'd5, v); check("R3 tx eob flag", v, 'h02);
    rreg(3'd4, v); check("R3 tx enable cleared", v & 2, 0);
    pulse_empty(); idle(4);
    rreg(3'd5, v); check("R10 idle flag when disabled", v, 'h82);
    check("R10 no fetch when disabled", ntx, 3);
    check("R10 irq_tx", int'(irq_tx), 1);
    wreg(3'd5, 16'h0082);

    // R9 block-select set
    wreg(3'd2, 16'h0020); wreg(3'd3, 16'd2); wreg(3'd4, 16'h000A);
    pulse_empty(); idle(6);
    check("R9 block-select stops shift-empty fetch", ntx, 3);
    pulse_txwr(); idle(6);
    check("R9 buffer write still fetches", ntx, 4);

    // R11 simultaneous requests
    wreg(3'd0, 16'h0090); wreg(3'd1, 16'd1); wreg(3'd4, 16'h0003);
    base = nacc;
    @(negedge clk); rx_byte = 8'h5C; rx_evt = 1; txbuf_wr = 1;
    @(negedge clk); rx_evt = 0; txbuf_wr = 0;
    idle(10);
    check("R11 two accesses", nacc, base + 2);
    check("R11 receive write first", int'(acc_we[base[5:0]]), 1);
    check("R11 transmit read second", int'(acc_we[6'(base + 1)]), 0);
    check("R11 rx data", int'(bmem[8'h90]), 'h5C);

    summary();
    $finish;
  end
endmodule